// File: doc/BRIEF.md
# Clock pulse-skipping throttler

This block slows a downstream clock domain by removing a chosen fraction of the clock pulses it passes on. Every cycle it produces a clock-enable bit for a gating cell outside the block. The throttle depth is the share of pulses removed, from 0 to 100 percent. It comes from one of two sources. The first is a direct percentage. The second is a 2-bit coarse level that decodes to one of four fixed percentages.

A modulo-100 accumulator spreads the removed pulses evenly across time rather than grouping them into bursts. A new depth is committed only on a cycle that already carries a pulse, so a change of depth never cuts a pulse short or leaves a stray one. The committed depth is brought out so the surrounding logic can see when a request has taken hold.

Top module: `pulse_skip_throttle`

## Requirements
- R1: While reset is asserted and right after it, `clk_en` is 1 and `depth_now` is 0.
- R2: With `level_mode` = 0 the requested depth is `pct_req`. A value above 100 is treated as 100.
- R3: With `level_mode` = 1 the requested depth is decoded from `lvl_req`: 0 gives 0, 1 gives 50, 2 gives 75 and 3 gives 85 percent. In this mode `pct_req` has no effect.
- R4: Take the cycle after `depth_now` changes. Over any 100 consecutive cycles from there on, while the depth holds, `clk_en` is high on exactly 100 minus `depth_now` cycles.
- R5: Let p = 100 - depth, with p > 0. Consecutive high cycles of `clk_en` are never more than ceil(100/p) cycles apart.
- R6: A committed depth of 0 keeps `clk_en` high on every cycle. A committed depth of 100 keeps it low on every cycle.
- R7: `depth_now` changes only in a cycle where `clk_en` is high. The one exception is when the previous depth was 100; then the change happens on the next clock.
- R8: The enable pattern follows the new depth from the first cycle after `depth_now` shows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the block |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_mode | input | 1 | 0 selects the percentage source, 1 selects the coded level |
| pct_req | input | 7 | Requested depth in percent |
| lvl_req | input | 2 | Coded level, 0 to 3 |
| clk_en | output | 1 | Per-cycle enable for the downstream clock gate |
| depth_now | output | 7 | Depth currently in force, in percent |

## Verification
A corrupted accumulator or a wrong pass amount shows up as a wrong count of enabled cycles within 100 cycles of a depth settling. It also shows up sooner as a gap between pulses that is too long for the depth. A commit taken at the wrong moment shows up in the same cycle: `depth_now` moves while `clk_en` is low, or it stays stuck after a change away from full skip. A bad level decode or a bad clamp is visible on `depth_now` as soon as the next pulse arrives.

// File: rtl/pulse_skip_throttle.sv
module pulse_skip_throttle #(
  parameter int SCALE    = 100,
  parameter int LVL1_PCT = 50,
  parameter int LVL2_PCT = 75,
  parameter int LVL3_PCT = 85
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_mode,
  input  logic [6:0] pct_req,
  input  logic [1:0] lvl_req,
  output logic       clk_en,
  output logic [6:0] depth_now
);
  localparam int W = 7;
  localparam logic [W-1:0] FULL = W'(SCALE);
  localparam logic [W:0]   FULL_X = (W+1)'(SCALE);

  logic [W-1:0] lvl_pct, req_depth, acc_q, pass_amt;
  logic [W:0]   sum;
  logic         wrap, commit;

  always_comb begin
    case (lvl_req)
      2'd0:    lvl_pct = '0;
      2'd1:    lvl_pct = W'(LVL1_PCT);
      2'd2:    lvl_pct = W'(LVL2_PCT);
      default: lvl_pct = W'(LVL3_PCT);
    endcase
  end

  assign req_depth = level_mode ? lvl_pct : ((pct_req > FULL) ? FULL : pct_req);
  assign pass_amt  = FULL - depth_now;
  assign sum       = {1'b0, acc_q} + {1'b0, pass_amt};
  assign wrap      = (sum >= FULL_X);
  assign commit    = wrap || (depth_now == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      depth_now <= '0;
      clk_en    <= 1'b1;
    end else begin
      acc_q  <= wrap ? W'(sum - FULL_X) : W'(sum);
      clk_en <= wrap;
      if (commit) depth_now <= req_depth;
    end
  end
endmodule

// File: rtl/pulse_skip_throttle_chk.sv
module pulse_skip_throttle_chk #(
  parameter int SCALE = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic [6:0] depth_now
);
  logic [6:0] prev_d, win, ecnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_d <= '0;
      win    <= '0;
      ecnt   <= '0;
    end else begin
      prev_d <= depth_now;
      if (depth_now != prev_d || win == 7'(SCALE - 1)) begin
        win  <= '0;
        ecnt <= '0;
      end else begin
        win  <= win + 7'd1;
        ecnt <= ecnt + 7'(clk_en);
      end
    end
  end

  a_r6_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_d == 7'd0) |-> clk_en);

  a_r6_full_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_d == 7'(SCALE)) |-> !clk_en);

  a_r7_commit_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_now != prev_d) |-> (clk_en || prev_d == 7'(SCALE)));

  a_r2_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
    depth_now <= 7'(SCALE));

  a_r4_window_count: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 7'(SCALE - 1) && depth_now == prev_d)
      |-> ({1'b0, ecnt} + 8'(clk_en) == 8'(SCALE) - {1'b0, depth_now}));
endmodule

bind pulse_skip_throttle pulse_skip_throttle_chk #(.SCALE(SCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .depth_now(depth_now)
);

// File: tb/pulse_skip_throttle_bench.sv
module pulse_skip_throttle_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       level_mode = 1'b0;
  logic [6:0] pct_req = '0;
  logic [1:0] lvl_req = '0;
  logic       clk_en;
  logic [6:0] depth_now;

  int total = 0;
  int bad = 0;
  int pushed = 0;
  int served = 0;

  typedef struct { int d; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  pulse_skip_throttle u_pulse_skip_throttle (
    .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
    .pct_req(pct_req), .lvl_req(lvl_req),
    .clk_en(clk_en), .depth_now(depth_now)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit lm, int pct, int lvl, int d, string tag);
    item_t it;
    @(negedge clk);
    level_mode = lm;
    pct_req = 7'(pct);
    lvl_req = 2'(lvl);
    it.d = d;
    it.tag = tag;
    q.push_back(it);
    pushed++;
    wait (served == pushed);
  endtask

  int last_d = 0;

  initial begin : monitor
    forever begin
      item_t it;
      int tmo, cnt, prev_idx, max_gap, lim, p;
      bit stable_ok;
      wait (q.size() != 0);
      it = q.pop_front();
      tmo = 0;
      @(negedge clk);
      while (int'(depth_now) != it.d && tmo < 400) begin
        @(negedge clk);
        tmo++;
      end
      check(int'(depth_now) == it.d, {it.tag, " depth commit"}, depth_now, it.d);
      if (int'(depth_now) != last_d)
        check(clk_en == 1'b1 || last_d == 100, "R7 change aligned with pulse", clk_en, 1);
      last_d = depth_now;
      cnt = 0; prev_idx = -1; max_gap = 0; stable_ok = 1'b1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (int'(depth_now) != it.d) stable_ok = 1'b0;
        if (clk_en) begin
          cnt++;
          if (prev_idx >= 0 && i - prev_idx > max_gap) max_gap = i - prev_idx;
          prev_idx = i;
        end
      end
      p = 100 - it.d;
      check(stable_ok, {it.tag, " R8 depth steady"}, depth_now, it.d);
      check(cnt == p, {it.tag, " R4 enable count"}, cnt, p);
      if (p > 0) begin
        lim = (100 + p - 1) / p;
        check(max_gap <= lim, {it.tag, " R5 max gap"}, max_gap, lim);
      end
      if (it.d == 0 || it.d == 100)
        check(cnt == p, {it.tag, " R6 constant enable"}, cnt, p);
      served++;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", served, pushed);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int cnt;
    repeat (3) @(negedge clk);
    check(clk_en == 1'b1, "R1 reset enable", clk_en, 1);
    check(depth_now == 7'd0, "R1 reset depth", depth_now, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_en == 1'b1 && depth_now == 7'd0, "R1 after reset", depth_now, 0);

    drive(0, 0, 0, 0, "R6 pct0");
    drive(0, 30, 0, 30, "R2 pct30");
    drive(0, 40, 0, 40, "R2 pct40");
    drive(0, 120, 0, 100, "R2 clamp120");
    drive(1, 0, 0, 0, "R3 lvl0 from full skip");
    drive(1, 0, 1, 50, "R3 lvl1");
    drive(1, 0, 2, 75, "R3 lvl2");
    drive(1, 0, 3, 85, "R3 lvl3");
    drive(0, 1, 0, 1, "R2 pct1");
    drive(0, 99, 0, 99, "R2 pct99");
    drive(0, 67, 0, 67, "R2 pct67");
    drive(0, 100, 0, 100, "R6 pct100");
    drive(1, 0, 2, 75, "R3 lvl2 again");

    @(negedge clk);
    pct_req = 7'd5;
    repeat (120) @(negedge clk);
    check(depth_now == 7'd75, "R3 pct ignored in level mode", depth_now, 75);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (clk_en) cnt++;
    end
    check(cnt == 25, "R3 pct ignored enable count", cnt, 25);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule